// File: doc/BRIEF.md
# Phase Error Scaler and Lock Detector

This block sits in the error path of a digital phase-locked loop. Each update cycle the loop presents a signed phase-error sample with a valid strobe. The block scales the sample down by a programmable power of two for the loop adder, using a sign-filling shift. It also judges whether the unscaled sample lies inside a programmable lock window.

A hysteretic lock flag is derived from that in-range judgement. While unlocked, the flag rises once enough consecutive in-range samples have been seen. While locked, it falls only after enough consecutive out-of-range samples. The two run lengths are set separately.

A configuration-error output warns software of two conditions: a gain code beyond the supported range, and a lock window wider than the loop's PWM period setting.

Top module: `pe_lock_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, `err_scaled` becomes 0, `out_of_range` becomes 0 and `lock_flag` becomes 0, and both run counters are cleared.
- R2: On a clock edge with `smp_valid` high, `err_scaled` takes `smp_err` arithmetically right-shifted by `gain_code` (codes 0 to 10), with the sign bit copied into every vacated upper bit.
- R3: A `gain_code` of 11 to 15 shifts by 10 and drives `cfg_err` high in the same cycle.
- R4: `cfg_err` is high whenever `lock_thr` is greater than `pwm_period`. With a legal gain code and `lock_thr` no greater than `pwm_period`, `cfg_err` is low.
- R5: On a clock edge with `smp_valid` high, `out_of_range` becomes 1 if the magnitude of `smp_err` is greater than `lock_thr`, and 0 otherwise. Equality counts as in range, and the magnitude of the most negative value is computed exactly.
- R6: While unlocked, each valid in-range sample advances the lock run count and each valid out-of-range sample clears it. `lock_flag` rises at the edge where the count reaches or exceeds `lock_ref`.
- R7: While locked, each valid out-of-range sample advances the unlock run count and each valid in-range sample clears it. `lock_flag` falls at the edge where the count reaches or exceeds `unlock_ref`.
- R8: On edges with `smp_valid` low, `err_scaled`, `out_of_range`, `lock_flag` and both run counters hold their values.
- R9: A `lock_ref` of 0 sets the flag on the first valid in-range sample. An `unlock_ref` of 0 clears it on the first valid out-of-range sample.
- R10: Both run counters clear whenever `lock_flag` changes. A relock therefore needs a full fresh run of `lock_ref` in-range samples. Both counters saturate at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Qualifies the error sample for this cycle |
| smp_err | input | 16 | Signed two's-complement phase error |
| gain_code | input | 4 | Right-shift amount; 0 to 10 legal |
| lock_thr | input | 16 | Unsigned lock window half-width |
| pwm_period | input | 16 | Loop PWM period setting, used only for the window check |
| lock_ref | input | 4 | In-range run length needed to lock |
| unlock_ref | input | 4 | Out-of-range run length needed to unlock |
| err_scaled | output | 16 | Registered scaled error for the loop adder |
| out_of_range | output | 1 | Registered out-of-window indicator of the last valid sample |
| lock_flag | output | 1 | Hysteretic lock status |
| cfg_err | output | 1 | Invalid gain code or window wider than PWM period |

## Verification
The hardest situation to reach from the ports is a stale run count surviving a change of lock state. For example, a lock count left over from before a lock could cause an instant relock after an unlock. The stimulus drives the block through a full lock, a broken unlock run and a completed unlock. It then shows that two in-range samples do not relock when the lock reference is 3.

A second case inserts idle cycles carrying out-of-range data in the middle of a partial run. A following valid sample then shows that the run neither broke nor advanced during the idle cycles.

// File: rtl/pe_lock_pkg.sv
// Package: shared constants, lock state type and saturating increment for
// the phase error scaler and lock detector.
// Assumes: run counters are 4 bits wide, matching the 4-bit reference fields.
package pe_lock_pkg;

    localparam int unsigned GAIN_W    = 4;
    localparam int unsigned CNT_W     = 4;
    localparam int unsigned MAX_SHIFT = 10;

    typedef enum logic {
        LS_HUNT = 1'b0,
        LS_HELD = 1'b1
    } lock_state_e;

    // Increments a run count, holding at all-ones instead of wrapping.
    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/pe_gain_shift.sv
// Module: pe_gain_shift
// Arithmetic right shift of a signed error by a 4-bit gain code, built as a
// log-depth chain of conditional power-of-two shift stages.
// Assumes: legal codes are 0..MAX_SHIFT; larger codes are clamped to
// MAX_SHIFT and reported through gain_bad. Purely combinational.
module pe_gain_shift
    import pe_lock_pkg::*;
#(
    parameter int unsigned ERR_W = 16
) (
    input  logic [GAIN_W-1:0]        gain_code,
    input  logic signed [ERR_W-1:0]  err_in,
    output logic signed [ERR_W-1:0]  err_out,
    output logic                     gain_bad
);

    localparam logic [GAIN_W-1:0] SHIFT_LIMIT = GAIN_W'(MAX_SHIFT);

    logic [GAIN_W-1:0] eff_shift;

    // Clamp out-of-range gain codes and flag them.
    always_comb begin
        gain_bad  = (gain_code > SHIFT_LIMIT);
        eff_shift = gain_bad ? SHIFT_LIMIT : gain_code;
    end

    // One stage per shift-amount bit; stage k shifts by 2**k when selected.
    for (genvar k = 0; k < GAIN_W; k++) begin : g_stage
        logic signed [ERR_W-1:0] d;
        logic signed [ERR_W-1:0] q;
        if (k == 0) begin : g_first
            assign d = err_in;
        end else begin : g_next
            assign d = g_stage[k-1].q;
        end
        assign q = eff_shift[k] ? (d >>> (2**k)) : d;
    end

    assign err_out = g_stage[GAIN_W-1].q;

endmodule

// File: rtl/pe_range_cmp.sv
// Module: pe_range_cmp
// Forms the magnitude of a signed error, compares it with the lock window,
// and checks that the window does not exceed the PWM period setting.
// Assumes: threshold and period are unsigned and ERR_W bits wide; the
// magnitude is carried in ERR_W+1 bits so the most negative value is exact.
module pe_range_cmp #(
    parameter int unsigned ERR_W = 16
) (
    input  logic signed [ERR_W-1:0] err_in,
    input  logic [ERR_W-1:0]        lock_thr,
    input  logic [ERR_W-1:0]        pwm_period,
    output logic                    outside,
    output logic                    thr_bad
);

    localparam int unsigned MAG_W = ERR_W + 1;

    logic [MAG_W-1:0] magnitude;
    logic [MAG_W-1:0] thr_ext;

    // Exact absolute value of the two's-complement error.
    always_comb begin
        if (err_in[ERR_W-1]) begin
            magnitude = {1'b0, ~err_in} + MAG_W'(1);
        end else begin
            magnitude = {1'b0, err_in};
        end
        thr_ext = {1'b0, lock_thr};
    end

    // Window test (equality counts as inside) and window-versus-period check.
    always_comb begin
        outside = (magnitude > thr_ext);
        thr_bad = (lock_thr > pwm_period);
    end

endmodule

// File: rtl/pe_lock_fsm.sv
// Module: pe_lock_fsm
// Hysteretic lock decision: a lock run counter active while hunting and an
// unlock run counter active while held, each with its own reference.
// Assumes: in_range is valid whenever sample_vld is high; counters saturate
// at all-ones; both counters clear on every change of lock state.
module pe_lock_fsm
    import pe_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_vld,
    input  logic             in_range,
    input  logic [CNT_W-1:0] lock_ref,
    input  logic [CNT_W-1:0] unlock_ref,
    output logic             lock_flag
);

    lock_state_e      state_q, state_d;
    logic [CNT_W-1:0] lk_cnt_q, lk_cnt_d;
    logic [CNT_W-1:0] ul_cnt_q, ul_cnt_d;
    logic [CNT_W-1:0] lk_next, ul_next;

    // Candidate run counts for this sample.
    always_comb begin
        lk_next = sat_inc(lk_cnt_q);
        ul_next = sat_inc(ul_cnt_q);
    end

    // Next-state and counter update for one qualified sample.
    always_comb begin
        state_d  = state_q;
        lk_cnt_d = lk_cnt_q;
        ul_cnt_d = ul_cnt_q;
        if (sample_vld) begin
            unique case (state_q)
                LS_HUNT: begin
                    if (!in_range) begin
                        lk_cnt_d = '0;
                    end else if (lk_next >= lock_ref) begin
                        state_d  = LS_HELD;
                        lk_cnt_d = '0;
                        ul_cnt_d = '0;
                    end else begin
                        lk_cnt_d = lk_next;
                    end
                end
                LS_HELD: begin
                    if (in_range) begin
                        ul_cnt_d = '0;
                    end else if (ul_next >= unlock_ref) begin
                        state_d  = LS_HUNT;
                        lk_cnt_d = '0;
                        ul_cnt_d = '0;
                    end else begin
                        ul_cnt_d = ul_next;
                    end
                end
                default: state_d = LS_HUNT;
            endcase
        end
    end

    // State and counter registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= LS_HUNT;
            lk_cnt_q <= '0;
            ul_cnt_q <= '0;
        end else begin
            state_q  <= state_d;
            lk_cnt_q <= lk_cnt_d;
            ul_cnt_q <= ul_cnt_d;
        end
    end

    assign lock_flag = (state_q == LS_HELD);

    // R6
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(sample_vld && in_range));

    // R7
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_flag) |-> $past(sample_vld && !in_range));

    // R10
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lock_flag) || $fell(lock_flag)) |-> (lk_cnt_q == '0 && ul_cnt_q == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> ($stable(lk_cnt_q) && $stable(ul_cnt_q) && $stable(state_q)));

endmodule

// File: rtl/pe_lock_detect.sv
// Module: pe_lock_detect (top)
// Phase error scaler and lock detector: registers the gain-scaled error and
// the out-of-range indicator on each valid sample and drives the hysteretic
// lock flag and the configuration-error output.
// Assumes: synchronous active-low reset; configuration inputs are static
// while samples flow; cfg_err is combinational from configuration.
module pe_lock_detect
    import pe_lock_pkg::*;
#(
    parameter int unsigned ERR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [ERR_W-1:0] smp_err,
    input  logic [GAIN_W-1:0]       gain_code,
    input  logic [ERR_W-1:0]        lock_thr,
    input  logic [ERR_W-1:0]        pwm_period,
    input  logic [CNT_W-1:0]        lock_ref,
    input  logic [CNT_W-1:0]        unlock_ref,
    output logic signed [ERR_W-1:0] err_scaled,
    output logic                    out_of_range,
    output logic                    lock_flag,
    output logic                    cfg_err
);

    logic signed [ERR_W-1:0] shifted;
    logic                    gain_bad;
    logic                    outside;
    logic                    thr_bad;

    pe_gain_shift #(.ERR_W(ERR_W)) u_shift (
        .gain_code (gain_code),
        .err_in    (smp_err),
        .err_out   (shifted),
        .gain_bad  (gain_bad)
    );

    pe_range_cmp #(.ERR_W(ERR_W)) u_range (
        .err_in     (smp_err),
        .lock_thr   (lock_thr),
        .pwm_period (pwm_period),
        .outside    (outside),
        .thr_bad    (thr_bad)
    );

    pe_lock_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (smp_valid),
        .in_range   (!outside),
        .lock_ref   (lock_ref),
        .unlock_ref (unlock_ref),
        .lock_flag  (lock_flag)
    );

    // Capture the scaled error and window result on each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_scaled   <= '0;
            out_of_range <= 1'b0;
        end else if (smp_valid) begin
            err_scaled   <= shifted;
            out_of_range <= outside;
        end
    end

    // Merge the two configuration checks.
    always_comb begin
        cfg_err = gain_bad | thr_bad;
    end

    // R3
    gain_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_code > GAIN_W'(MAX_SHIFT)) |-> cfg_err);

    // R4
    thr_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_thr > pwm_period) |-> cfg_err);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(err_scaled) && $stable(out_of_range) && $stable(lock_flag)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (err_scaled == '0 && !out_of_range && !lock_flag));

endmodule

// File: tb/tb_pe_lock_detect.sv
`timescale 1ns/1ps
module tb_pe_lock_detect;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid = 1'b0;
    logic signed [15:0] smp_err = '0;
    logic [3:0]         gain_code = '0;
    logic [15:0]        lock_thr = 16'd50;
    logic [15:0]        pwm_period = 16'd1000;
    logic [3:0]         lock_ref = 4'd3;
    logic [3:0]         unlock_ref = 4'd2;
    logic signed [15:0] err_scaled;
    logic               out_of_range;
    logic               lock_flag;
    logic               cfg_err;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pe_lock_detect dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_err(smp_err),
        .gain_code(gain_code), .lock_thr(lock_thr), .pwm_period(pwm_period),
        .lock_ref(lock_ref), .unlock_ref(unlock_ref), .err_scaled(err_scaled),
        .out_of_range(out_of_range), .lock_flag(lock_flag), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one valid sample; return at the next falling edge.
    task automatic send(input logic signed [15:0] e);
        @(negedge clk);
        smp_err = e;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b1;
        smp_err = 16'sd999;
        @(negedge clk);
        check("R1 err_scaled", err_scaled, 0);
        check("R1 out_of_range", out_of_range, 0);
        check("R1 lock_flag", lock_flag, 0);
        smp_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_shift();
        do_reset();
        gain_code = 4'd0;  send(16'sd1234);
        check("R2 gain0", err_scaled, 1234);
        gain_code = 4'd3;  send(-16'sd100);
        check("R2 gain3 neg", err_scaled, -13);
        gain_code = 4'd5;  send(-16'sd1000);
        check("R2 gain5 neg", err_scaled, -32);
        gain_code = 4'd10; send(16'sh7FFF);
        check("R2 gain10 pos", err_scaled, 31);
        send(-16'sd1);
        check("R2 gain10 minus one", err_scaled, -1);
        check("R2 cfg_err low", cfg_err, 0);
        gain_code = 4'd12; send(-16'sd32768);
        check("R3 gain12 clamps", err_scaled, -32);
        check("R3 cfg_err", cfg_err, 1);
        gain_code = 4'd15; send(16'sd2048);
        check("R3 gain15 clamps", err_scaled, 2);
        gain_code = 4'd0;
    endtask

    task automatic t_cfg();
        lock_thr = 16'd100; pwm_period = 16'd99;
        #1 check("R4 window above period", cfg_err, 1);
        pwm_period = 16'd100;
        #1 check("R4 window equals period", cfg_err, 0);
        lock_thr = 16'd50; pwm_period = 16'd1000;
    endtask

    task automatic t_range();
        do_reset();
        lock_ref = 4'd15; unlock_ref = 4'd15;
        send(16'sd50);  check("R5 +thr inside", out_of_range, 0);
        send(16'sd51);  check("R5 +thr+1 outside", out_of_range, 1);
        send(-16'sd50); check("R5 -thr inside", out_of_range, 0);
        send(-16'sd51); check("R5 -thr-1 outside", out_of_range, 1);
        lock_thr = 16'd32767; pwm_period = 16'hFFFF;
        send(-16'sd32768); check("R5 most negative outside", out_of_range, 1);
        send(16'sd32767);  check("R5 max positive inside", out_of_range, 0);
        lock_thr = 16'd50; pwm_period = 16'd1000;
    endtask

    task automatic t_lock();
        do_reset();
        lock_ref = 4'd3; unlock_ref = 4'd2;
        send(16'sd10); send(-16'sd20);
        check("R6 two in-range not locked", lock_flag, 0);
        send(16'sd300);
        check("R6 out-of-range breaks run", lock_flag, 0);
        send(16'sd1); send(16'sd2);
        check("R6 restarted run short", lock_flag, 0);
        send(16'sd3);
        check("R6 locks on third", lock_flag, 1);
        send(16'sd400);
        check("R7 one out-of-range holds", lock_flag, 1);
        send(16'sd0);
        send(-16'sd400);
        check("R7 in-range broke unlock run", lock_flag, 1);
        send(-16'sd400);
        check("R7 unlocks on second", lock_flag, 0);
        send(16'sd5); send(16'sd5);
        check("R10 no carried lock count", lock_flag, 0);
        send(16'sd5);
        check("R10 fresh run relocks", lock_flag, 1);
    endtask

    task automatic t_idle();
        do_reset();
        lock_ref = 4'd3; unlock_ref = 4'd2;
        gain_code = 4'd1;
        send(16'sd8); send(16'sd8);
        @(negedge clk);
        smp_err = 16'sd5000;
        repeat (4) @(negedge clk);
        check("R8 scaled held", err_scaled, 4);
        check("R8 range held", out_of_range, 0);
        check("R8 lock held", lock_flag, 0);
        send(16'sd8);
        check("R8 run count kept", lock_flag, 1);
        gain_code = 4'd0;
    endtask

    task automatic t_zero_ref();
        do_reset();
        lock_ref = 4'd0; unlock_ref = 4'd0;
        send(16'sd900);
        check("R9 out-of-range no lock", lock_flag, 0);
        send(16'sd7);
        check("R9 first in-range locks", lock_flag, 1);
        send(16'sd900);
        check("R9 first out-of-range unlocks", lock_flag, 0);
    endtask

    task automatic t_sat();
        do_reset();
        lock_ref = 4'd15; unlock_ref = 4'd1;
        for (int i = 0; i < 14; i++) send(16'sd1);
        check("R10 fourteen short of fifteen", lock_flag, 0);
        send(16'sd1);
        check("R10 locks at fifteen", lock_flag, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-requirements: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_shift();
        t_cfg();
        t_range();
        t_lock();
        t_idle();
        t_zero_ref();
        t_sat();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule